// File: doc/BRIEF.md
# Repeated String Move/Compare Sequencer

This block runs one repeated string operation from a single start command. At start it loads three working registers: a source pointer, a destination pointer and a byte count. It then loops through the two strings one byte per iteration over a single-port synchronous byte memory. On each iteration it advances both pointers and reduces the count. No per-byte operands are supplied from outside: the registers themselves locate the strings and bound their length.

There are two modes. Move copies the source string to the destination. Compare checks the two strings byte by byte and stops at the first difference. When the loop ends, a one-cycle completion pulse is raised. The final pointer and count values stay visible on the outputs, and in compare mode a flag reports whether a difference was found.

Top module: `str_seq`

## Requirements
- R1: After reset, done_o and mismatch_o are 0, no memory request is made, and src_o, dst_o and cnt_o are 0.
- R2: A start_i pulse while idle loads src_i, dst_i and cnt_i into the working registers. mode_i selects the operation: 0 is move and 1 is compare.
- R3: A move iteration takes two cycles. In the first, a read is requested at the source pointer (mem_req_o=1, mem_we_o=0). In the second, the returned byte is written at the destination pointer (mem_req_o=1, mem_we_o=1). An n-byte move issues 2n requests, n of them writes.
- R4: Every completed iteration adds 1 to each pointer, modulo 2^AW, and subtracts 1 from the count.
- R5: A compare iteration takes three cycles: a read at the source pointer, a read at the destination pointer, then a compare cycle with no memory request. A compare never writes memory.
- R6: In compare mode the loop stops at the first unequal byte pair and sets mismatch_o. The pointers are left one past the unequal bytes, and the count includes the unequal byte in its decrement.
- R7: A compare over equal strings runs the full count and ends with mismatch_o at 0.
- R8: A start with cnt_i equal to 0 makes no memory request. It raises done_o in the next cycle, with the outputs equal to the loaded values.
- R9: done_o is high for exactly one cycle, in the cycle after the final iteration. For an n-byte run that is 2n+1 cycles after the start edge for a move, and 3k+1 cycles for a compare that stops after k bytes. The final register values are valid then and are held until the next start.
- R10: start_i is ignored while an operation is in progress.
- R11: mismatch_o holds its value after done_o and is cleared by the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| mode_i | input | 1 | 0 = move, 1 = compare |
| src_i | input | AW | Initial source pointer |
| dst_i | input | AW | Initial destination pointer |
| cnt_i | input | CW | Byte count |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write enable for the request |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after the request |
| done_o | output | 1 | One-cycle completion pulse |
| mismatch_o | output | 1 | Compare found a difference |
| src_o | output | AW | Current source pointer |
| dst_o | output | AW | Current destination pointer |
| cnt_o | output | CW | Current count |

## Verification
The bench builds the block with AW=8 and CW=8, so that a 256-byte memory model covers the whole address space. With that width, a source string that starts at 0xFD crosses the top of memory and exercises the pointer wrap. The narrow count keeps exact cycle counting for every run cheap while leaving room for multi-byte moves, full-length compares and an early-stopping compare.

// File: rtl/str_seq_pkg.sv
package str_seq_pkg;
  typedef enum logic {OP_MOVE = 1'b0, OP_CMP = 1'b1} op_e;
  // ST_LAST: write cycle for move, compare cycle for compare
  typedef enum logic [1:0] {ST_IDLE, ST_RD_SRC, ST_RD_DST, ST_LAST} st_e;
endpackage

// File: rtl/str_seq_regs.sv
module str_seq_regs #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o,
  output logic          cnt_one_o
);
  localparam int NPTR = 2;

  logic [NPTR-1:0][AW-1:0] ptr_init, ptr_q;
  logic [CW-1:0]           cnt_q;

  assign ptr_init = {dst_i, src_i};

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ptr_q[g] <= '0;
      else if (load_i) ptr_q[g] <= ptr_init[g];
      else if (step_i) ptr_q[g] <= ptr_q[g] + AW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= cnt_i;
    else if (step_i) cnt_q <= cnt_q - CW'(1);
  end

  assign src_o     = ptr_q[0];
  assign dst_o     = ptr_q[1];
  assign cnt_o     = cnt_q;
  assign cnt_one_o = (cnt_q == CW'(1));

  // R4
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (ptr_q[0] == $past(ptr_q[0]) + AW'(1)) &&
               (ptr_q[1] == $past(ptr_q[1]) + AW'(1)) &&
               (cnt_q == $past(cnt_q) - CW'(1)));

  // R2
  load_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ptr_q[0] == $past(src_i)) && (ptr_q[1] == $past(dst_i)) &&
               (cnt_q == $past(cnt_i)));
endmodule

// File: rtl/str_seq_ctrl.sv
module str_seq_ctrl
  import str_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       mode_i,
  input  logic       cnt_in_zero_i,
  input  logic       cnt_one_i,
  input  logic [7:0] rdata_i,
  output logic       load_o,
  output logic       step_o,
  output logic       req_o,
  output logic       we_o,
  output logic       addr_dst_o,
  output logic [7:0] wdata_o,
  output logic       done_o,
  output logic       mismatch_o
);
  st_e        state_q, state_d;
  op_e        mode_q;
  logic [7:0] byte_q;
  logic       done_q, miss_q;
  logic       fin, miss;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    step_o     = 1'b0;
    req_o      = 1'b0;
    we_o       = 1'b0;
    addr_dst_o = 1'b0;
    fin        = 1'b0;
    miss       = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        if (cnt_in_zero_i) fin = 1'b1;
        else               state_d = ST_RD_SRC;
      end
      ST_RD_SRC: begin
        req_o   = 1'b1;
        state_d = (mode_q == OP_CMP) ? ST_RD_DST : ST_LAST;
      end
      ST_RD_DST: begin
        req_o      = 1'b1;
        addr_dst_o = 1'b1;
        state_d    = ST_LAST;
      end
      ST_LAST: begin
        step_o = 1'b1;
        if (mode_q == OP_MOVE) begin
          req_o      = 1'b1;
          we_o       = 1'b1;
          addr_dst_o = 1'b1;
        end else if (rdata_i != byte_q) begin
          miss = 1'b1;
        end
        if (miss || cnt_one_i) begin
          fin     = 1'b1;
          state_d = ST_IDLE;
        end else begin
          state_d = ST_RD_SRC;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= OP_MOVE;
      byte_q  <= '0;
      done_q  <= 1'b0;
      miss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (load_o) mode_q <= op_e'(mode_i);
      // source byte returns in the cycle after its read
      if (state_q == ST_RD_DST) byte_q <= rdata_i;
      if (load_o)    miss_q <= 1'b0;
      else if (miss) miss_q <= 1'b1;
    end
  end

  assign wdata_o    = rdata_i;
  assign done_o     = done_q;
  assign mismatch_o = miss_q;

  // R3
  move_wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ($past(state_q) == ST_RD_SRC) && (mode_q == OP_MOVE));

  // R5
  cmp_seq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LAST && mode_q == OP_CMP) |-> $past(state_q) == ST_RD_DST);

  // R6
  miss_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miss_q) |-> done_q && (state_q == ST_IDLE));

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE) && !req_o);
endmodule

// File: rtl/str_seq.sv
module str_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [CW-1:0] cnt_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          mismatch_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [CW-1:0] cnt_o
);
  logic load, step, addr_dst, cnt_one;

  str_seq_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i, .rst_ni,
    .load_i    (load),
    .step_i    (step),
    .src_i, .dst_i, .cnt_i,
    .src_o, .dst_o, .cnt_o,
    .cnt_one_o (cnt_one)
  );

  str_seq_ctrl u_ctrl (
    .clk_i, .rst_ni, .start_i, .mode_i,
    .cnt_in_zero_i (cnt_i == '0),
    .cnt_one_i     (cnt_one),
    .rdata_i       (mem_rdata_i),
    .load_o        (load),
    .step_o        (step),
    .req_o         (mem_req_o),
    .we_o          (mem_we_o),
    .addr_dst_o    (addr_dst),
    .wdata_o       (mem_wdata_o),
    .done_o, .mismatch_o
  );

  assign mem_addr_o = addr_dst ? dst_o : src_o;

  // R9
  done_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mismatch_o) |-> cnt_o == '0);

  // R3
  we_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_req_o && $past(mem_req_o) && !$past(mem_we_o));
endmodule

// File: tb/str_seq_test.sv
`timescale 1ns/1ps
module str_seq_test;
  localparam int AW = 8;
  localparam int CW = 8;
  localparam int MSZ = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, mode = 1'b0;
  logic [AW-1:0] src = '0, dst = '0;
  logic [CW-1:0] cnt = '0;
  logic mem_req, mem_we, done, mismatch;
  logic [AW-1:0] mem_addr, src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [7:0] mem_wdata, mem_rdata;

  logic [7:0] mem [MSZ];
  logic bd_we = 1'b0;
  logic [AW-1:0] bd_addr = '0;
  logic [7:0] bd_data = '0;
  int n_acc = 0, n_wr = 0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  str_seq #(.AW(AW), .CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .src_i(src), .dst_i(dst), .cnt_i(cnt),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .done_o(done), .mismatch_o(mismatch),
    .src_o(src_q), .dst_o(dst_q), .cnt_o(cnt_q)
  );

  always @(posedge clk) begin
    if (bd_we) mem[bd_addr] <= bd_data;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (mem_req) n_acc <= n_acc + 1;
    if (mem_req && mem_we) n_wr <= n_wr + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input int d);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = AW'(a); bd_data = 8'(d);
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  // returns cycles from start edge to done; pokes a start at cycle busy_at
  task automatic run(input bit m, input int s, input int d, input int c,
                     input int busy_at, output int lat, output int acc, output int wr);
    int a0, w0;
    a0 = n_acc; w0 = n_wr;
    @(negedge clk);
    start = 1'b1; mode = m; src = AW'(s); dst = AW'(d); cnt = CW'(c);
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      if (lat == busy_at) begin
        start = 1'b1; mode = ~m; src = 8'h77; dst = 8'h99; cnt = 8'h3;
      end else start = 1'b0;
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    acc = n_acc - a0; wr = n_wr - w0;
  endtask

  task automatic check_pulse(input string req);
    logic [AW-1:0] s0, d0;
    logic [CW-1:0] c0;
    s0 = src_q; d0 = dst_q; c0 = cnt_q;
    @(negedge clk);
    chk(done == 1'b0, req, "done width", int'(done), 0);
    chk(src_q == s0 && dst_q == d0 && cnt_q == c0, req, "held regs",
        int'(src_q), int'(s0));
  endtask

  task automatic t_reset();
    chk(done == 0 && mismatch == 0, "R1", "done/mismatch", int'({done, mismatch}), 0);
    chk(mem_req == 0, "R1", "mem_req", int'(mem_req), 0);
    chk(src_q == 0 && dst_q == 0 && cnt_q == 0, "R1", "regs", int'(src_q | dst_q | cnt_q), 0);
  endtask

  task automatic t_move(input int s, input int d, input int n, input string tag);
    int lat, acc, wr;
    for (int i = 0; i < n; i++) poke((s + i) % MSZ, 8'hA0 + i * 7);
    for (int i = 0; i < n; i++) poke((d + i) % MSZ, 0);
    run(1'b0, s, d, n, 0, lat, acc, wr);
    chk(lat == 2 * n + 1, "R9", {tag, " move latency"}, lat, 2 * n + 1);
    chk(acc == 2 * n && wr == n, "R3", {tag, " accesses"}, acc, 2 * n);
    chk(wr == n, "R3", {tag, " writes"}, wr, n);
    for (int i = 0; i < n; i++)
      chk(mem[(d + i) % MSZ] == 8'(8'hA0 + i * 7), "R3", {tag, " copied byte"},
          int'(mem[(d + i) % MSZ]), int'(8'(8'hA0 + i * 7)));
    chk(src_q == AW'(s + n), "R4", {tag, " src end"}, int'(src_q), (s + n) % MSZ);
    chk(dst_q == AW'(d + n), "R4", {tag, " dst end"}, int'(dst_q), (d + n) % MSZ);
    chk(cnt_q == 0 && mismatch == 0, "R4", {tag, " cnt end"}, int'(cnt_q), 0);
    check_pulse("R9");
  endtask

  task automatic t_zero();
    int lat, acc, wr;
    run(1'b0, 8'h33, 8'h44, 0, 0, lat, acc, wr);
    chk(lat == 1, "R8", "zero latency", lat, 1);
    chk(acc == 0, "R8", "zero accesses", acc, 0);
    chk(src_q == 8'h33 && dst_q == 8'h44 && cnt_q == 0, "R8", "zero regs", int'(src_q), 8'h33);
    check_pulse("R9");
  endtask

  // diff_at < 0: equal strings; otherwise byte index that differs
  task automatic t_cmp(input int s, input int d, input int n, input int diff_at);
    int lat, acc, wr, k;
    for (int i = 0; i < n; i++) begin
      poke(s + i, 8'h11 * i + 3);
      poke(d + i, (i == diff_at) ? 8'h11 * i + 4 : 8'h11 * i + 3);
    end
    k = (diff_at < 0) ? n : diff_at + 1;
    run(1'b1, s, d, n, 0, lat, acc, wr);
    chk(lat == 3 * k + 1, "R5", "cmp latency", lat, 3 * k + 1);
    chk(acc == 2 * k, "R5", "cmp reads", acc, 2 * k);
    chk(wr == 0, "R5", "cmp writes", wr, 0);
    if (diff_at < 0) begin
      chk(mismatch == 0, "R7", "equal mismatch", int'(mismatch), 0);
      chk(cnt_q == 0 && src_q == AW'(s + n), "R7", "equal regs", int'(src_q), s + n);
    end else begin
      chk(mismatch == 1, "R6", "mismatch flag", int'(mismatch), 1);
      chk(src_q == AW'(s + k) && dst_q == AW'(d + k), "R6", "stop ptrs", int'(src_q), s + k);
      chk(cnt_q == CW'(n - k), "R6", "stop cnt", int'(cnt_q), n - k);
    end
    check_pulse("R9");
  endtask

  task automatic t_miss_hold();
    int lat, acc, wr;
    repeat (3) @(negedge clk);
    chk(mismatch == 1, "R11", "mismatch held", int'(mismatch), 1);
    run(1'b1, 8'h10, 8'h20, 0, 0, lat, acc, wr);
    chk(mismatch == 0, "R11", "mismatch cleared", int'(mismatch), 0);
  endtask

  task automatic t_busy();
    int lat, acc, wr;
    for (int i = 0; i < 4; i++) poke(8'h60 + i, 8'h5A ^ i);
    run(1'b0, 8'h60, 8'h80, 4, 3, lat, acc, wr);
    chk(lat == 9, "R10", "busy latency", lat, 9);
    chk(src_q == 8'h64 && dst_q == 8'h84 && cnt_q == 0, "R10", "busy regs", int'(src_q), 8'h64);
    chk(wr == 4 && mem[8'h83] == (8'h5A ^ 8'h3), "R10", "busy copy", int'(mem[8'h83]), 8'h59);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_move(8'h10, 8'h40, 5, "basic");
    t_move(8'hFD, 8'h20, 4, "wrap");
    t_zero();
    t_cmp(8'h90, 8'hB0, 6, -1);
    t_cmp(8'hC0, 8'hD0, 8, 2);
    t_miss_hold();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule